// File: doc/BRIEF.md
# External Memory Bus Controller

This block sits between a CPU-side request port and an external parallel memory bus. Each request carries a 24-bit byte address, a read or write flag, a byte or halfword size and write data. The block works out whether the address belongs to an on-chip region or to one of six external chip-select windows. For an external target it runs a fixed bus sequence: a setup cycle, a strobe phase stretched by that select's wait states, and a hold cycle. It then returns a single-cycle ready pulse, together with the read data when the request was a read.

Each chip select has its own configuration: an enable, an output polarity, a data width of 8 or 16 bits and a wait-state count. The windows overlap, and a fixed priority resolves each address to at most one select. On a 16-bit bus the block steers bytes onto the correct lane and drives active-low byte enables. On an 8-bit bus it splits a halfword into two byte cycles and rebuilds the result in little-endian order.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset every chip-select pin sits at its inactive level, where the inactive level is the inverse of that select's polarity bit. Both strobes and both byte enables are high, and ready and the data output enable are low.
- R2: Addresses in the on-chip ranges never assert a chip select, a strobe or a byte enable. These ranges are 00_0000h–01_FFFFh, RAM_LO–FF_BFFFh (default RAM_LO is FF_B000h) and FF_E000h–FF_FFFFh. Such a request pulses ready in the cycle after it is accepted, and the read data is 0.
- R3: Before priority is applied, the select windows are as follows. Select 0 covers all addresses. Select 1 covers 80_0000h and up. Select 2 covers F0_0000h and up, and also FF_C000h–FF_C7FFh. Select 3 covers FF_C800h–FF_CFFFh, select 4 covers FF_D000h–FF_D7FFh and select 5 covers FF_D800h–FF_DFFFh.
- R4: When several enabled windows contain the address, only the highest-numbered select is asserted. At most one select is asserted at any time.
- R5: A disabled select never asserts and passes the address to the next lower enabled window. If no enabled window matches, the request completes like an on-chip access.
- R6: Pin i is asserted at level high when polarity bit i is 1, and at level low when it is 0.
- R7: An external access lasts one setup cycle, then 1+N strobe cycles, then one hold cycle, where N is the select's wait count. Ready is high for exactly one cycle after the last hold cycle. For a request accepted at edge k, ready is seen in cycle k + beats·(N+3) + 1.
- R8: A byte write on a 16-bit bus places the byte on both D[7:0] and D[15:8]. An even address drives low-lane enable ble_n low, and an odd address drives high-lane enable bhe_n low.
- R9: A halfword on a 16-bit bus ignores address bit 0. It drives both byte enables low, places write data unchanged on D[15:0], and returns D[15:0] as read data.
- R10: A halfword on an 8-bit bus runs two complete beats, first at the even address and then at the odd address. The first beat carries bits 7:0 on D[7:0] and the second carries bits 15:8. Read data is rebuilt with the even byte in bits 7:0. Only ble_n is asserted on an 8-bit bus.
- R11: A byte read returns the addressed byte zero-extended. On a 16-bit bus the byte comes from D[15:8] at odd addresses and from D[7:0] at even addresses. On an 8-bit bus it always comes from D[7:0].
- R12: The read strobe is pulsed only for reads and the write strobe only for writes, and the two are never low together. The data output enable is high only during a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with ready |
| cfg_cs_en | input | 6 | Per-select enable |
| cfg_cs_act_hi | input | 6 | Per-select polarity, 1 = active-high |
| cfg_cs_wide | input | 6 | Per-select width, 1 = 16-bit |
| cfg_cs_wait | input | 6·WAIT_W | Per-select wait count, select i at bits i·WAIT_W |
| bus_addr | output | 24 | External address |
| bus_dout | output | 16 | External write data |
| bus_dout_en | output | 1 | Drive enable for write data |
| bus_din | input | 16 | External read data |
| bus_rd_n | output | 1 | Read strobe, active-low |
| bus_wr_n | output | 1 | Write strobe, active-low |
| bus_bhe_n | output | 1 | High byte enable, active-low |
| bus_ble_n | output | 1 | Low byte enable, active-low |
| bus_cs | output | 6 | Chip selects, polarity per select |

## Verification
The bench uses WAIT_W = 4 and the default RAM_LO. It programs wait counts from 0 to 3 across the selects, makes selects 1 and 3 8-bit, and makes select 2 active-high. With this setup, zero-wait and multi-wait strobe phases, two-beat halfwords and mixed polarity all appear in one table pass. Later passes turn off individual selects and flip a polarity bit, which exercises the fall-through paths and the case where no select matches at all.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int EBC_AW  = 24;
  localparam int EBC_DW  = 16;
  localparam int EBC_NCS = 6;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE} ebc_state_e;

  function automatic logic in_span(input logic [EBC_AW-1:0] a,
                                   input logic [EBC_AW-1:0] lo,
                                   input logic [EBC_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Raw window membership per select, before enables and priority
  function automatic logic [EBC_NCS-1:0] window_hits(input logic [EBC_AW-1:0] a);
    logic [EBC_NCS-1:0] h;
    h[0] = 1'b1;
    h[1] = (a >= 24'h80_0000);
    h[2] = (a >= 24'hF0_0000) || in_span(a, 24'hFF_C000, 24'hFF_C7FF);
    h[3] = in_span(a, 24'hFF_C800, 24'hFF_CFFF);
    h[4] = in_span(a, 24'hFF_D000, 24'hFF_D7FF);
    h[5] = in_span(a, 24'hFF_D800, 24'hFF_DFFF);
    return h;
  endfunction

  function automatic logic is_onchip(input logic [EBC_AW-1:0] a,
                                     input logic [EBC_AW-1:0] ram_lo);
    return (a <= 24'h01_FFFF) || in_span(a, ram_lo, 24'hFF_BFFF) || (a >= 24'hFF_E000);
  endfunction

  // Address of the current beat: halfwords step from the even byte
  function automatic logic [EBC_AW-1:0] beat_addr(input logic [EBC_AW-1:0] a,
                                                  input logic half, input logic beat);
    return half ? {a[EBC_AW-1:1], beat} : a;
  endfunction

  // Data placed on the bus for a write beat
  function automatic logic [EBC_DW-1:0] write_lanes(input logic wide, input logic half,
                                                    input logic beat,
                                                    input logic [EBC_DW-1:0] wd);
    logic [7:0] b;
    if (wide && half) return wd;
    b = (half && beat) ? wd[15:8] : wd[7:0];
    return {b, b};
  endfunction

  // {bhe_n, ble_n} while an access is in progress
  function automatic logic [1:0] lane_enables(input logic wide, input logic half,
                                              input logic a0);
    if (!wide) return 2'b10;
    if (half)  return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction
endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
  import ebc_pkg::*;
#(
  parameter logic [EBC_AW-1:0] RAM_LO = 24'hFF_B000
) (
  input  logic [EBC_AW-1:0]  addr,
  input  logic [EBC_NCS-1:0] en,
  output logic [EBC_NCS-1:0] sel_oh,
  output logic               bypass
);
  logic [EBC_NCS-1:0] hit_en;
  logic [EBC_NCS-1:0] sel_raw;
  logic [EBC_NCS:0]   taken_above;
  logic               onchip;

  assign hit_en = window_hits(addr) & en;
  assign onchip = is_onchip(addr, RAM_LO);
  assign taken_above[EBC_NCS] = 1'b0;

  // Priority chain: highest index wins
  for (genvar i = EBC_NCS - 1; i >= 0; i--) begin : g_prio
    assign sel_raw[i]     = hit_en[i] & ~taken_above[i+1];
    assign taken_above[i] = taken_above[i+1] | hit_en[i];
  end

  assign sel_oh = onchip ? '0 : sel_raw;
  assign bypass = onchip | ~(|sel_raw);
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bypass,
  input  logic              two_beats,
  input  logic [WAIT_W-1:0] waits,
  output logic              idle,
  output logic              access,
  output logic              in_strobe,
  output logic              capture,
  output logic              beat,
  output logic              ready
);
  ebc_state_e        st;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      beat <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= bypass ? ST_DONE : ST_SETUP;
          beat <= 1'b0;
        end
        ST_SETUP: begin
          st  <= ST_STROBE;
          cnt <= '0;
        end
        ST_STROBE: begin
          if (cnt == waits) st <= ST_HOLD;
          else              cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (two_beats && !beat) begin
            beat <= 1'b1;
            st   <= ST_SETUP;
          end else begin
            st <= ST_DONE;
          end
        end
        default: begin
          st   <= ST_IDLE;
          beat <= 1'b0;
        end
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign in_strobe = (st == ST_STROBE);
  assign access    = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
  assign capture   = in_strobe && (cnt == waits);
  assign ready     = (st == ST_DONE);

  // Independent strobe-length tally for the checks below
  logic [WAIT_W:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                strobe_run <= '0;
    else if (st == ST_SETUP)   strobe_run <= '0;
    else if (st == ST_STROBE)  strobe_run <= strobe_run + 1'b1;
  end

  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (strobe_run == ({1'b0, waits} + 1'b1)));
  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R7
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_strobe) |-> $past(access));
endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes
  import ebc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              act,
  input  logic              capture,
  input  logic              wr,
  input  logic              half,
  input  logic              wide,
  input  logic              beat,
  input  logic [EBC_AW-1:0] addr,
  input  logic [EBC_DW-1:0] wdata,
  input  logic [EBC_DW-1:0] din,
  output logic [EBC_AW-1:0] bus_addr,
  output logic [EBC_DW-1:0] dout,
  output logic              dout_en,
  output logic              bhe_n,
  output logic              ble_n,
  output logic [EBC_DW-1:0] rdata
);
  logic [1:0] en_pair;

  assign bus_addr = beat_addr(addr, half, beat);
  assign dout_en  = act & wr;
  assign dout     = dout_en ? write_lanes(wide, half, beat, wdata) : '0;
  assign en_pair  = act ? lane_enables(wide, half, bus_addr[0]) : 2'b11;
  assign bhe_n    = en_pair[1];
  assign ble_n    = en_pair[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clear) begin
      rdata <= '0;
    end else if (capture && !wr) begin
      if (wide) begin
        if (half)             rdata <= din;
        else if (bus_addr[0]) rdata <= {8'h00, din[15:8]};
        else                  rdata <= {8'h00, din[7:0]};
      end else if (half) begin
        if (beat) rdata[15:8] <= din[7:0];
        else      rdata[7:0]  <= din[7:0];
      end else begin
        rdata <= {8'h00, din[7:0]};
      end
    end
  end

  // R8
  byte_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && wide && !half) |-> (dout[15:8] == dout[7:0]));
  // R9
  half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && wide && half) |-> (!bhe_n && !ble_n && !bus_addr[0]));
  // R10
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !wide) |-> (bhe_n && !ble_n));
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int                WAIT_W = 4,
  parameter logic [EBC_AW-1:0] RAM_LO = 24'hFF_B000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_half,
  input  logic [EBC_AW-1:0]         req_addr,
  input  logic [EBC_DW-1:0]         req_wdata,
  output logic                      req_ready,
  output logic [EBC_DW-1:0]         req_rdata,
  input  logic [EBC_NCS-1:0]        cfg_cs_en,
  input  logic [EBC_NCS-1:0]        cfg_cs_act_hi,
  input  logic [EBC_NCS-1:0]        cfg_cs_wide,
  input  logic [EBC_NCS*WAIT_W-1:0] cfg_cs_wait,
  output logic [EBC_AW-1:0]         bus_addr,
  output logic [EBC_DW-1:0]         bus_dout,
  output logic                      bus_dout_en,
  input  logic [EBC_DW-1:0]         bus_din,
  output logic                      bus_rd_n,
  output logic                      bus_wr_n,
  output logic                      bus_bhe_n,
  output logic                      bus_ble_n,
  output logic [EBC_NCS-1:0]        bus_cs
);
  localparam int NCS = EBC_NCS;

  logic [NCS-1:0]    sel_oh, cs_lat, cs_on;
  logic              bypass, idle, access, in_strobe, capture, beat, start;
  logic              wide_sel, wr_lat, half_lat, wide_lat;
  logic [WAIT_W-1:0] wait_sel, wait_lat;
  logic [EBC_AW-1:0] addr_lat;
  logic [EBC_DW-1:0] wdata_lat;

  ebc_decode #(.RAM_LO(RAM_LO)) u_dec (
    .addr(req_addr), .en(cfg_cs_en), .sel_oh(sel_oh), .bypass(bypass));

  always_comb begin
    wide_sel = 1'b0;
    wait_sel = '0;
    for (int i = 0; i < NCS; i++) begin
      wide_sel = wide_sel | (sel_oh[i] & cfg_cs_wide[i]);
      wait_sel = wait_sel | ({WAIT_W{sel_oh[i]}} & cfg_cs_wait[i*WAIT_W +: WAIT_W]);
    end
  end

  assign start = req_valid & idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_lat    <= '0;
      wr_lat    <= 1'b0;
      half_lat  <= 1'b0;
      wide_lat  <= 1'b1;
      wait_lat  <= '0;
      addr_lat  <= '0;
      wdata_lat <= '0;
    end else if (start) begin
      cs_lat    <= sel_oh;
      wr_lat    <= req_write;
      half_lat  <= req_half;
      wide_lat  <= bypass ? 1'b1 : wide_sel;
      wait_lat  <= wait_sel;
      addr_lat  <= req_addr;
      wdata_lat <= req_wdata;
    end
  end

  ebc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
    .two_beats(half_lat & ~wide_lat), .waits(wait_lat),
    .idle(idle), .access(access), .in_strobe(in_strobe),
    .capture(capture), .beat(beat), .ready(req_ready));

  ebc_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .clear(start), .act(access), .capture(capture),
    .wr(wr_lat), .half(half_lat), .wide(wide_lat), .beat(beat),
    .addr(addr_lat), .wdata(wdata_lat), .din(bus_din),
    .bus_addr(bus_addr), .dout(bus_dout), .dout_en(bus_dout_en),
    .bhe_n(bus_bhe_n), .ble_n(bus_ble_n), .rdata(req_rdata));

  assign bus_rd_n = ~(in_strobe & ~wr_lat);
  assign bus_wr_n = ~(in_strobe & wr_lat);

  for (genvar i = 0; i < NCS; i++) begin : g_cs_pin
    assign cs_on[i]  = access & cs_lat[i];
    assign bus_cs[i] = cfg_cs_act_hi[i] ? cs_on[i] : ~cs_on[i];
  end

  // R4
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs ~^ cfg_cs_act_hi));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  // R5
  strobe_has_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (|(bus_cs ~^ cfg_cs_act_hi)));
  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && (bus_cs == ~cfg_cs_act_hi)));
endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
  typedef struct packed {
    logic        wr;
    logic        half;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [2:0]  cs;   // 6 = no select expected
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b0, 24'h00_1000, 16'h0000, 3'd6},
    {1'b1, 1'b1, 24'h03_0000, 16'h1234, 3'd0},
    {1'b1, 1'b0, 24'h03_0001, 16'h00AB, 3'd0},
    {1'b0, 1'b1, 24'h80_0010, 16'h0000, 3'd1},
    {1'b1, 1'b1, 24'h80_0020, 16'h5678, 3'd1},
    {1'b0, 1'b0, 24'h90_0003, 16'h0000, 3'd1},
    {1'b1, 1'b0, 24'hF0_0004, 16'h00C5, 3'd2},
    {1'b0, 1'b1, 24'hFF_C100, 16'h0000, 3'd2},
    {1'b0, 1'b1, 24'hFF_C800, 16'h0000, 3'd3},
    {1'b1, 1'b0, 24'hFF_D123, 16'h0077, 3'd4},
    {1'b0, 1'b0, 24'hFF_DFFE, 16'h0000, 3'd5},
    {1'b0, 1'b1, 24'hFF_B400, 16'h0000, 3'd6},
    {1'b1, 1'b1, 24'hFF_E010, 16'h9999, 3'd6},
    {1'b0, 1'b1, 24'h01_FFFE, 16'h0000, 3'd6},
    {1'b0, 1'b0, 24'h02_0000, 16'h0000, 3'd0},
    {1'b0, 1'b1, 24'hFF_A000, 16'h0000, 3'd2},
    {1'b0, 1'b1, 24'h80_0031, 16'h0000, 3'd1},
    {1'b1, 1'b0, 24'hFF_C803, 16'h0042, 3'd3},
    {1'b0, 1'b0, 24'hFF_D001, 16'h0000, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] req_rdata;
  logic [5:0]  cfg_en = 6'h3F, cfg_hi = 6'b000100, cfg_wide = 6'b110101;
  logic [23:0] cfg_wait = {4'd1, 4'd0, 4'd3, 4'd2, 4'd1, 4'd0};
  logic [23:0] bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic        bus_dout_en, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n;
  logic [5:0]  bus_cs;
  logic        narrow_cur = 1'b0;
  int          checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  ext_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_half(req_half), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .cfg_cs_en(cfg_en),
    .cfg_cs_act_hi(cfg_hi), .cfg_cs_wide(cfg_wide), .cfg_cs_wait(cfg_wait),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n), .bus_cs(bus_cs));

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always_comb begin
    if (narrow_cur) bus_din = {8'hEE, mem(bus_addr)};
    else            bus_din = {mem(bus_addr | 24'h1), mem(bus_addr & ~24'h1)};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic run(input vec_t v, input string cs_tag);
    bit          skip = (v.cs == 3'd6);
    bit          wide = skip ? 1'b1 : cfg_wide[v.cs];
    int          nw = skip ? 0 : int'(cfg_wait[v.cs*4 +: 4]);
    int          beats = (!skip && v.half && !wide) ? 2 : 1;
    int          exp_lat = skip ? 1 : beats * (nw + 3) + 1;
    int          exp_str = skip ? 0 : beats * (nw + 1);
    logic [23:0] ab = v.half ? {v.addr[23:1], 1'b0} : v.addr;
    logic [5:0]  exp_cs = skip ? 6'b0 : (6'b1 << v.cs);
    logic [5:0]  cs_or = '0;
    logic [23:0] a_first = '0, a_last = '0;
    logic [15:0] d_first = '0, d_last = '0, got = '0, exp_d;
    logic [1:0]  en_first = 2'b11, exp_en;
    int          n = 0, strobes = 0, bad_strobe = 0, bad_oe = 0;
    bit          seen = 0, done = 0;
    narrow_cur = !wide;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_half = v.half;
    req_addr = v.addr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 200) begin
      n++;
      cs_or |= (bus_cs ~^ cfg_hi);
      if (v.wr ? !bus_rd_n : !bus_wr_n) bad_strobe++;
      if (bus_dout_en && !v.wr) bad_oe++;
      if (!bus_rd_n || !bus_wr_n) begin
        strobes++;
        if (!seen) begin
          seen = 1; a_first = bus_addr; d_first = bus_dout; en_first = {bus_bhe_n, bus_ble_n};
          if (v.wr && !bus_dout_en) bad_oe++;
        end
        a_last = bus_addr; d_last = bus_dout;
      end
      if (req_ready) begin
        done = 1; got = req_rdata;
      end else begin
        @(negedge clk);
      end
    end
    chk(cs_or == exp_cs, cs_tag, 32'(cs_or), 32'(exp_cs));
    chk(n == exp_lat, "R7 latency", n, exp_lat);
    chk(strobes == exp_str, "R7 strobe cycles", strobes, exp_str);
    chk(bad_strobe == 0 && bad_oe == 0, "R12 strobe kind / output enable", bad_strobe + bad_oe, 0);
    if (!skip) begin
      chk(a_first == ab, v.half ? "R9 first address" : "R8 address", a_first, ab);
      exp_en = !wide ? 2'b10 : (v.half ? 2'b00 : (v.addr[0] ? 2'b01 : 2'b10));
      chk(en_first == exp_en, wide ? "R8/R9 byte enables" : "R10 byte enables", en_first, exp_en);
      if (beats == 2) chk(a_last == (ab | 24'h1), "R10 second beat address", a_last, ab | 24'h1);
      if (v.wr) begin
        if (wide && v.half) exp_d = v.wdata;
        else                exp_d = {v.wdata[7:0], v.wdata[7:0]};
        if (wide) chk(d_first == exp_d, v.half ? "R9 write data" : "R8 mirrored byte", d_first, exp_d);
        else      chk(d_first[7:0] == v.wdata[7:0], "R10 first write byte", d_first[7:0], v.wdata[7:0]);
        if (beats == 2) chk(d_last[7:0] == v.wdata[15:8], "R10 second write byte", d_last[7:0], v.wdata[15:8]);
      end
    end
    if (!v.wr) begin
      if (skip)        exp_d = 16'h0000;
      else if (v.half) exp_d = {mem(ab | 24'h1), mem(ab)};
      else             exp_d = {8'h00, mem(v.addr)};
      chk(got == exp_d, skip ? "R2 read data" : (v.half ? "R10/R9 read data" : "R11 read data"), got, exp_d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs == ~cfg_hi, "R1 cs idle", bus_cs, ~cfg_hi);
    chk({bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n} == 4'hF, "R1 strobes/enables",
        {bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n}, 4'hF);
    chk(!req_ready && !bus_dout_en, "R1 ready/oe", {req_ready, bus_dout_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs == ~cfg_hi, "R1 cs idle after release", bus_cs, ~cfg_hi);

    for (int i = 0; i < NV; i++) run(VEC[i], "R3/R4 select");

    // R5: select 4 off falls back to select 2
    cfg_en = 6'b101111;
    run({1'b0, 1'b0, 24'hFF_D000, 16'h0, 3'd2}, "R5 disabled fall-through");
    // R5: select 2 off falls back to select 1
    cfg_en = 6'b111011;
    run({1'b1, 1'b1, 24'hF0_0100, 16'hBEEF, 3'd1}, "R5 disabled fall-through");
    // R5: select 0 off leaves the low region unmapped
    cfg_en = 6'b111110;
    run({1'b0, 1'b1, 24'h03_0000, 16'h0, 3'd6}, "R5 unmapped");
    cfg_en = 6'h3F;

    // R6: polarity flip on selects 0 and 2
    cfg_hi = 6'b000001;
    @(negedge clk);
    chk(bus_cs == 6'b111110, "R6 idle levels", bus_cs, 6'b111110);
    run({1'b0, 1'b0, 24'h03_0002, 16'h0, 3'd0}, "R6 active-high select");
    run({1'b0, 1'b0, 24'hF8_0002, 16'h0, 3'd2}, "R6 active-low select");

    finish_run();
  end
endmodule